// File: doc/BRIEF.md
# First-Word-Fall-Through Dual-Clock FIFO with Programmable Level Flags

This block moves words from a write clock domain to an unrelated read clock domain. The first word written into an empty FIFO is placed on the read data output without any read request. The read side sees an active-low output-ready flag that means "a word is on the bus now". A read request consumes that word and the next one falls through. The write side sees an active-high input-ready flag. Both sides also get a programmable level flag: almost-empty on the read side and almost-full on the write side. Their offsets are set per instance by parameters.

Both sides follow a valid/ready handshake.
- Write side: a write is offered when `wr_en_n` and `wr_cs_n` are both low. It completes on a write-clock edge only if `in_ready` is high at that edge. An offer made while `in_ready` is low is dropped, not held, so the source applies back-pressure by waiting for `in_ready`.
- Read side: the FIFO offers a word while `out_ready_n` is low. The sink accepts it by holding `rd_en_n` low at a read-clock edge.
- `rd_cs_n` only controls the output-enable that stands in for a tristate driver.

The pointers cross the domains as Gray code through two-flop synchronisers. The read output register counts as one storage slot, so the FIFO holds DEPTH+1 words.

Top module: `fwft_dcfifo`

## Requirements
- R1: A word is stored only on a `wr_clk` rising edge at which `wr_en_n` is low, `wr_cs_n` is low and `in_ready` is high. If either select is high, the edge has no effect.
- R2: After the first word enters an empty FIFO, `out_ready_n` goes low and `rd_data` shows that word with no read request.
- R3: With no reads, `in_ready` drops to 0 at the `wr_clk` edge that accepts word DEPTH+1, provided the first word has already reached the output. Writes offered while `in_ready` is 0 are discarded.
- R4: In a full FIFO, one accepted read brings `in_ready` back to 1. It is still 0 just after the first `wr_clk` edge following the read edge.
- R5: `almost_empty_n` is 0 while the held count is between 0 and AE_OFS+1. It is 1 once AE_OFS+2 or more words are held.
- R6: `almost_full_n` is 0 while the held count is at least DEPTH+1−AF_OFS, and 1 below that. AF_OFS lies in 1..DEPTH.
- R7: Reading the last word sets `out_ready_n` to 1. Read requests while `out_ready_n` is 1 change nothing: a later write is the next word seen, with a held count of one.
- R8: `rd_oe` is the inverse of `rd_cs_n` at all times, including when the FIFO is empty or full.
- R9: For a write into an empty FIFO, `out_ready_n` is still 1 after the second `rd_clk` rising edge following the accepting `wr_clk` edge. It is 0 after the third.
- R10: While `arst_n` is low and after its release, with no traffic, the flags read `out_ready_n`=1, `in_ready`=1, `almost_empty_n`=0 and `almost_full_n`=1.
- R11: Words leave in the order they were accepted, with none lost or duplicated, for any ratio of the two clocks. Each Gray pointer changes by at most one bit per edge of its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| arst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_n | input | 1 | Write request, active low |
| wr_cs_n | input | 1 | Write chip select, active low |
| wr_data | input | WIDTH | Word to store |
| in_ready | output | 1 | 1 when a write can be accepted |
| almost_full_n | output | 1 | 0 when the held count is at least DEPTH+1−AF_OFS |
| rd_en_n | input | 1 | Read request, active low |
| rd_cs_n | input | 1 | Output select, active low |
| rd_data | output | WIDTH | Word at the head of the FIFO |
| rd_oe | output | 1 | Output-enable standing in for the tristate driver |
| out_ready_n | output | 1 | 0 when `rd_data` holds a valid word |
| almost_empty_n | output | 1 | 0 when the held count is at most AE_OFS+1 |

## Verification
The bench drives the FIFO to its DEPTH+1 limit one word at a time and checks both level flags at every count. A design that forgot the output register would flag full one word early, and one with an off-by-one threshold would move a flag at the wrong count. It offers writes into a full FIFO and reads into an empty one. A pointer that moved anyway would show up later as a duplicated or missing word, or a wrong count. It counts read-clock edges after the first write, which catches an output-ready path with too few or too many stages. Long random traffic at several clock ratios catches a bad Gray crossing, which would reorder or lose words.

// File: rtl/fwft_pkg.sv
`timescale 1ns/1ps
package fwft_pkg;

  // Binary to reflected Gray code.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary, MSB first.
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/fwft_gray_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser for a Gray-coded pointer.
module fwft_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fwft_wr_ctrl.sv
`timescale 1ns/1ps
// Write-domain pointer, full detection and almost-full flag.
module fwft_wr_ctrl #(
  parameter int DEPTH  = 16,
  parameter int AF_OFS = 3,
  parameter int PW     = 5
) (
  input  logic          wr_clk,
  input  logic          arst_n,
  input  logic          wr_req,
  input  logic [PW-1:0] rmem_gs,   // memory-drain pointer, synced
  input  logic [PW-1:0] cons_gs,   // consumed pointer, synced
  output logic [PW-1:0] wptr_b,
  output logic [PW-1:0] wptr_g,
  output logic          in_ready,
  output logic          almost_full_n,
  output logic          wr_fire
);
  import fwft_pkg::*;

  localparam logic [PW-1:0] MEM_FULL = PW'(DEPTH);
  localparam logic [PW-1:0] AF_TH    = PW'(DEPTH + 1 - AF_OFS);

  logic [PW-1:0] wptr_nx, rmem_b, cons_b, mem_cnt, held_cnt;

  always_comb begin
    wr_fire  = wr_req & in_ready;
    wptr_nx  = wptr_b + PW'(wr_fire);
    rmem_b   = PW'(gray2bin(32'(rmem_gs)));
    cons_b   = PW'(gray2bin(32'(cons_gs)));
    mem_cnt  = wptr_nx - rmem_b;
    held_cnt = wptr_nx - cons_b;
  end

  always_ff @(posedge wr_clk or negedge arst_n) begin
    if (!arst_n) begin
      wptr_b        <= '0;
      wptr_g        <= '0;
      in_ready      <= 1'b1;
      almost_full_n <= 1'b1;
    end else begin
      wptr_b        <= wptr_nx;
      wptr_g        <= PW'(bin2gray(32'(wptr_nx)));
      in_ready      <= (mem_cnt != MEM_FULL);
      almost_full_n <= (held_cnt < AF_TH);
    end
  end
endmodule

// File: rtl/fwft_rd_ctrl.sv
`timescale 1ns/1ps
// Read-domain fall-through output register, pointers and almost-empty flag.
module fwft_rd_ctrl #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter int AE_OFS = 2,
  parameter int PW     = 5
) (
  input  logic             rd_clk,
  input  logic             arst_n,
  input  logic             rd_req,
  input  logic [PW-1:0]    wptr_gs,
  input  logic [WIDTH-1:0] mem_q,
  output logic [PW-1:0]    rptr_b,
  output logic [PW-1:0]    rptr_g,
  output logic [PW-1:0]    cons_b,
  output logic [PW-1:0]    cons_g,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_ready_n,
  output logic             almost_empty_n
);
  import fwft_pkg::*;

  localparam logic [PW-1:0] AE_TH = PW'(AE_OFS + 2);

  logic [PW-1:0] wb, rptr_nx, cons_nx, held_cnt;
  logic          valid, rd_fire, load;

  always_comb begin
    wb       = PW'(gray2bin(32'(wptr_gs)));
    valid    = ~out_ready_n;
    rd_fire  = rd_req & valid;
    load     = (wb != rptr_b) & (~valid | rd_fire);
    rptr_nx  = rptr_b + PW'(load);
    cons_nx  = cons_b + PW'(rd_fire);
    held_cnt = wb - cons_nx;
  end

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n) begin
      rptr_b         <= '0;
      rptr_g         <= '0;
      cons_b         <= '0;
      cons_g         <= '0;
      rd_data        <= '0;
      out_ready_n    <= 1'b1;
      almost_empty_n <= 1'b0;
    end else begin
      rptr_b         <= rptr_nx;
      rptr_g         <= PW'(bin2gray(32'(rptr_nx)));
      cons_b         <= cons_nx;
      cons_g         <= PW'(bin2gray(32'(cons_nx)));
      if (load) rd_data <= mem_q;
      out_ready_n    <= ~(load | (valid & ~rd_fire));
      almost_empty_n <= (held_cnt >= AE_TH);
    end
  end
endmodule

// File: rtl/fwft_dcfifo.sv
`timescale 1ns/1ps
// Top: storage array, both domain controllers and the three pointer crossings.
module fwft_dcfifo #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 3
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             arst_n,
  input  logic             wr_en_n,
  input  logic             wr_cs_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_ready,
  output logic             almost_full_n,
  input  logic             rd_en_n,
  input  logic             rd_cs_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic             out_ready_n,
  output logic             almost_empty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_b, wptr_g, wptr_gs;
  logic [PW-1:0] rptr_b, rptr_g, rptr_gs;
  logic [PW-1:0] cons_b, cons_g, cons_gs;
  logic          wr_fire;
  logic [WIDTH-1:0] mem_q;
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[wptr_b[AW-1:0]] <= wr_data;
  end
  assign mem_q = mem[rptr_b[AW-1:0]];

  assign rd_oe = ~rd_cs_n;

  fwft_wr_ctrl #(.DEPTH(DEPTH), .AF_OFS(AF_OFS), .PW(PW)) u_wr (
    .wr_clk        (wr_clk),
    .arst_n        (arst_n),
    .wr_req        (~wr_en_n & ~wr_cs_n),
    .rmem_gs       (rptr_gs),
    .cons_gs       (cons_gs),
    .wptr_b        (wptr_b),
    .wptr_g        (wptr_g),
    .in_ready      (in_ready),
    .almost_full_n (almost_full_n),
    .wr_fire       (wr_fire)
  );

  fwft_rd_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AE_OFS(AE_OFS), .PW(PW)) u_rd (
    .rd_clk         (rd_clk),
    .arst_n         (arst_n),
    .rd_req         (~rd_en_n),
    .wptr_gs        (wptr_gs),
    .mem_q          (mem_q),
    .rptr_b         (rptr_b),
    .rptr_g         (rptr_g),
    .cons_b         (cons_b),
    .cons_g         (cons_g),
    .rd_data        (rd_data),
    .out_ready_n    (out_ready_n),
    .almost_empty_n (almost_empty_n)
  );

  fwft_gray_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .arst_n(arst_n), .d(wptr_g), .q(wptr_gs));
  fwft_gray_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .arst_n(arst_n), .d(rptr_g), .q(rptr_gs));
  fwft_gray_sync #(.W(PW)) u_sync_c2w (
    .clk(wr_clk), .arst_n(arst_n), .d(cons_g), .q(cons_gs));
endmodule

// File: rtl/fwft_dcfifo_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the FIFO top.
module fwft_dcfifo_chk #(
  parameter int PW = 5
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          arst_n,
  input logic          wr_en_n,
  input logic          wr_cs_n,
  input logic          in_ready,
  input logic          almost_full_n,
  input logic          rd_en_n,
  input logic          out_ready_n,
  input logic [PW-1:0] wptr_b,
  input logic [PW-1:0] wptr_g,
  input logic [PW-1:0] rptr_g,
  input logic [PW-1:0] cons_b
);
  // R1: a deselected or idle write edge leaves the write pointer alone
  a_r1_select_gate: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (wr_en_n || wr_cs_n) |=> $stable(wptr_b));

  // R3: no store while full
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (!in_ready && !wr_en_n && !wr_cs_n) |=> $stable(wptr_b));

  // R6: a full FIFO always reports almost-full
  a_r6_full_implies_af: assert property (@(posedge wr_clk) disable iff (!arst_n)
    !in_ready |-> !almost_full_n);

  // R7: nothing is consumed while no word is presented
  a_r7_no_underflow: assert property (@(posedge rd_clk) disable iff (!arst_n)
    out_ready_n |=> $stable(cons_b));

  // R7: output-ready only returns high as the result of a read
  a_r7_empty_after_read: assert property (@(posedge rd_clk) disable iff (!arst_n)
    $rose(out_ready_n) |-> $past(!rd_en_n));

  // R11: Gray pointers step by at most one bit
  a_r11_wgray_step: assert property (@(posedge wr_clk) disable iff (!arst_n)
    $countones(wptr_g ^ $past(wptr_g)) <= 1);

  a_r11_rgray_step: assert property (@(posedge rd_clk) disable iff (!arst_n)
    $countones(rptr_g ^ $past(rptr_g)) <= 1);
endmodule

bind fwft_dcfifo fwft_dcfifo_chk #(.PW(PW)) u_chk (
  .wr_clk        (wr_clk),
  .rd_clk        (rd_clk),
  .arst_n        (arst_n),
  .wr_en_n       (wr_en_n),
  .wr_cs_n       (wr_cs_n),
  .in_ready      (in_ready),
  .almost_full_n (almost_full_n),
  .rd_en_n       (rd_en_n),
  .out_ready_n   (out_ready_n),
  .wptr_b        (wptr_b),
  .wptr_g        (wptr_g),
  .rptr_g        (rptr_g),
  .cons_b        (cons_b)
);

// File: tb/fwft_dcfifo_tb_top.sv
`timescale 1ns/1ps
module fwft_dcfifo_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int AE    = 2;
  localparam int AF    = 3;

  logic wr_clk = 1'b0, rd_clk = 1'b0, arst_n = 1'b0;
  logic wr_en_n = 1'b1, wr_cs_n = 1'b1, rd_en_n = 1'b1, rd_cs_n = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic in_ready, almost_full_n, rd_oe, out_ready_n, almost_empty_n;
  logic [WIDTH-1:0] rd_data;

  real rd_half = 5.0;
  always #5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  fwft_dcfifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AE_OFS(AE), .AF_OFS(AF)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
    .wr_en_n(wr_en_n), .wr_cs_n(wr_cs_n), .wr_data(wr_data),
    .in_ready(in_ready), .almost_full_n(almost_full_n),
    .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rd_data(rd_data), .rd_oe(rd_oe),
    .out_ready_n(out_ready_n), .almost_empty_n(almost_empty_n));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [WIDTH-1:0] sb_q[$];
  int wr_pend = 0, rd_pend = 0, wr_pct = 0, rd_pct = 0;
  bit wr_rand = 0, rd_rand = 0, cs_hold = 0;
  int seq = 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Write driver: pushes each word it expects the FIFO to accept.
  always @(negedge wr_clk) begin
    wr_en_n = 1'b1;
    wr_cs_n = 1'b0;
    if (arst_n && (wr_pend > 0 || (wr_rand && $urandom_range(0, 99) < wr_pct))) begin
      if (wr_pend > 0) wr_pend--;
      wr_data = WIDTH'(seq);
      wr_en_n = 1'b0;
      wr_cs_n = cs_hold;
      if (in_ready && !cs_hold) sb_q.push_back(WIDTH'(seq));
      seq++;
    end
  end

  // Read driver and monitor: a read decided now consumes the current head.
  always @(negedge rd_clk) begin
    rd_en_n = 1'b1;
    if (arst_n && (rd_pend > 0 || (rd_rand && $urandom_range(0, 99) < rd_pct))) begin
      if (rd_pend > 0) rd_pend--;
      rd_en_n = 1'b0;
      if (!out_ready_n) begin
        if (sb_q.size() == 0) chk(1'b0, "R11 unexpected word", rd_data, 0);
        else chk(rd_data == sb_q[0], "R11 order", rd_data, sb_q[0]);
        if (sb_q.size() != 0) void'(sb_q.pop_front());
      end
    end
  end

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      report();
      $finish;
    end
  end

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    #1;
  endtask

  // Issue one write and return just after its accepting edge.
  task automatic write_one();
    wr_pend = 1;
    wait (wr_pend == 0);
    @(posedge wr_clk);
    #1;
  endtask

  task automatic read_one();
    rd_pend = 1;
    wait (rd_pend == 0);
    @(posedge rd_clk);
    #1;
  endtask

  function automatic bit ae_exp(int n);
    return n >= AE + 2;
  endfunction
  function automatic bit af_exp(int n);
    return !(n >= DEPTH + 1 - AF);
  endfunction

  int held = 0;

  initial begin
    repeat (3) @(posedge wr_clk);
    #1;
    chk(out_ready_n == 1 && in_ready == 1, "R10 in reset", {out_ready_n, in_ready}, 2'b11);
    chk(almost_empty_n == 0 && almost_full_n == 1, "R10 in reset lvl",
        {almost_empty_n, almost_full_n}, 2'b01);
    @(negedge wr_clk) arst_n = 1'b1;
    settle();
    chk(out_ready_n == 1 && in_ready == 1 && almost_empty_n == 0 && almost_full_n == 1,
        "R10 after release", {out_ready_n, in_ready, almost_empty_n, almost_full_n}, 4'b1101);

    // R1: write offered with chip select high is dropped
    cs_hold = 1;
    wr_pend = 3;
    wait (wr_pend == 0);
    settle();
    chk(out_ready_n == 1, "R1 deselected write", out_ready_n, 1);
    cs_hold = 0;

    // R9 and R2: first word falls through after exactly three read edges
    write_one();
    held = 1;
    repeat (2) @(posedge rd_clk);
    #1;
    chk(out_ready_n == 1, "R9 still empty after two edges", out_ready_n, 1);
    @(posedge rd_clk);
    #1;
    chk(out_ready_n == 0, "R9 ready after third edge", out_ready_n, 0);
    chk(rd_data == sb_q[0], "R2 head shown without read", rd_data, sb_q[0]);
    settle();
    chk(almost_empty_n == ae_exp(held), "R5 level at 1", almost_empty_n, ae_exp(held));

    // R3, R5, R6: fill to DEPTH+1 with no reads
    for (int i = 2; i <= DEPTH + 1; i++) begin
      write_one();
      held = i;
      chk(in_ready == (i < DEPTH + 1), "R3 input ready at write edge", in_ready, i < DEPTH + 1);
      settle();
      chk(almost_empty_n == ae_exp(held), "R5 almost-empty fill", almost_empty_n, ae_exp(held));
      chk(almost_full_n == af_exp(held), "R6 almost-full fill", almost_full_n, af_exp(held));
    end

    // R3: writes while full are discarded
    wr_pend = 2;
    wait (wr_pend == 0);
    settle();
    chk(in_ready == 0, "R3 stays full", in_ready, 0);
    chk(sb_q.size() == DEPTH + 1, "R3 no extra accepted", sb_q.size(), DEPTH + 1);

    // R8: output enable follows select while full
    rd_cs_n = 1'b1;
    #1 chk(rd_oe == 0, "R8 deselected full", rd_oe, 0);
    rd_cs_n = 1'b0;
    #1 chk(rd_oe == 1, "R8 selected full", rd_oe, 1);

    // R4: one read from full restores input ready, not instantly
    read_one();
    held = DEPTH;
    @(posedge wr_clk);
    #1;
    chk(in_ready == 0, "R4 not yet ready", in_ready, 0);
    settle();
    chk(in_ready == 1, "R4 ready after read", in_ready, 1);

    // R5, R6, R7: drain one at a time
    while (held > 0) begin
      read_one();
      held--;
      settle();
      chk(almost_empty_n == ae_exp(held), "R5 almost-empty drain", almost_empty_n, ae_exp(held));
      chk(almost_full_n == af_exp(held), "R6 almost-full drain", almost_full_n, af_exp(held));
    end
    chk(out_ready_n == 1, "R7 empty after last read", out_ready_n, 1);

    // R7: reads while empty are ignored
    rd_pend = 3;
    wait (rd_pend == 0);
    settle();
    chk(out_ready_n == 1, "R7 still empty", out_ready_n, 1);
    rd_cs_n = 1'b1;
    #1 chk(rd_oe == 0, "R8 deselected empty", rd_oe, 0);
    rd_cs_n = 1'b0;
    #1 chk(rd_oe == 1, "R8 selected empty", rd_oe, 1);
    write_one();
    settle();
    chk(out_ready_n == 0, "R7 new word shown", out_ready_n, 0);
    chk(almost_empty_n == 0 && almost_full_n == 1, "R7 count is one",
        {almost_empty_n, almost_full_n}, 2'b01);
    chk(rd_data == sb_q[0], "R7 head is new word", rd_data, sb_q[0]);
    read_one();
    settle();

    // R11: random traffic at several clock ratios
    for (int ph = 0; ph < 4; ph++) begin
      case (ph)
        0: begin rd_half = 5.0;  wr_pct = 60; rd_pct = 60; end
        1: begin rd_half = 3.7;  wr_pct = 80; rd_pct = 40; end
        2: begin rd_half = 11.3; wr_pct = 30; rd_pct = 90; end
        default: begin rd_half = 7.9; wr_pct = 70; rd_pct = 70; end
      endcase
      wr_rand = 1; rd_rand = 1;
      repeat (2000) @(posedge wr_clk);
      wr_rand = 0;
      rd_pct = 100;
      while (sb_q.size() != 0) @(posedge wr_clk);
      settle();
      rd_rand = 0;
      settle();
      chk(out_ready_n == 1 && sb_q.size() == 0, "R11 drained", sb_q.size(), 0);
    end

    done = 1;
    report();
    $finish;
  end
endmodule